// File: doc/BRIEF.md
# Parallel ATA PIO Cycle Sequencer

This block carries out a single programmed-I/O transfer on a parallel ATA bus each time it is asked. The request gives a five-bit register select code, a read or write flag, a 16-bit write value and a flag that chooses between the 8-bit register timing set and the 16-bit data timing set. The block places the chip selects and address and waits out the setup time. It then pulls the chosen strobe low for the active time and releases it. Before it returns to idle it keeps the address valid for a recovery tail. Read data is taken from the bus as the read strobe rises and is presented with a one-clock done pulse.

Each timing set holds four clock counts: setup, active, minimum recovery and full cycle. When IORDY use is enabled, the device can stretch the active phase. The pin goes through a synchronizer and is not looked at until a fixed number of clocks into the strobe. The stretch has a hard upper bound. A transfer that reaches that bound releases the strobe and sets a sticky timeout flag. For writes, the data bus stays driven for a few clocks after the write strobe rises, and the number of clocks depends on the PIO mode.

Top module: `ata_pio_seq`

## Requirements
- R1: Out of reset and whenever busy is low, cs0_n, cs1_n, rd_n and wr_n are all high, dd_oe is low, and done is low except for its pulse.
- R2: A request (req_valid high) starts a transfer only while busy is low. Request inputs that change while busy is high have no effect on the running transfer and start no further transfer.
- R3: The select code is decoded as bit 0 to cs0_n, bit 1 to cs1_n and bits 4:2 to da. These values are held for every busy clock. Busy begins the clock after acceptance with a setup phase of S clocks in which both strobes are high.
- R4: After setup, only the matching strobe goes low: rd_n for a read (req_write=0) and wr_n for a write (req_write=1). Without IORDY it stays low for exactly A clocks, and the two strobes are never low together.
- R5: On a read, rdata takes the dd_in value present in the last clock of the active phase, which is the value on the bus as rd_n rises. It is valid while done is high.
- R6: On a write, dd_oe is high and dd_out equals the write value for every clock that wr_n is low. dd_oe then stays high for min(H, tail) clocks after wr_n rises, where H is 3 for mode 0, 2 for modes 1 and 2, and 1 for any other mode. dd_oe is low for reads.
- R7: req_wide=1 picks the data timing set (dat_*), and req_wide=0 picks the register set (reg_*). The set is taken when the request is accepted.
- R8: With iordy_en high, the active phase ends at the first clock n (counted from 1) for which n ≥ A, n ≥ IORDY_MIN+1, and the IORDY value after the two-flop synchronizer is high.
- R9: With iordy_en high, the active phase never goes beyond max(A, IORDY_MIN+1, ACT_MAX) clocks. If it ends at that limit while the synchronized IORDY is low, iordy_timeout is set and stays set until reset.
- R10: The tail after the strobe rises lasts max(C − n, R, 1) clocks, where n is the active length including any stretch and the subtraction saturates at 0. The address stays valid during the tail. done is high for exactly the first clock after the tail, with busy low.
- R11: A setup or active count of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 5 | Register select code: da in bits 4:2, cs1_n in bit 1, cs0_n in bit 0 |
| req_wide | input | 1 | 1 = data timing set, 0 = register timing set |
| req_wdata | input | DW | Write value |
| pio_mode | input | 3 | PIO mode, sets the write hold |
| iordy_en | input | 1 | Enable IORDY stretching |
| reg_setup | input | CNT_W | Register set: setup clocks |
| reg_active | input | CNT_W | Register set: active clocks |
| reg_recov | input | CNT_W | Register set: minimum recovery clocks |
| reg_cycle | input | CNT_W | Register set: cycle clocks |
| dat_setup | input | CNT_W | Data set: setup clocks |
| dat_active | input | CNT_W | Data set: active clocks |
| dat_recov | input | CNT_W | Data set: minimum recovery clocks |
| dat_cycle | input | CNT_W | Data set: cycle clocks |
| iordy_in | input | 1 | IORDY pin (asynchronous) |
| dd_in | input | DW | Data bus input |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock end-of-transfer pulse |
| rdata | output | DW | Captured read data |
| iordy_timeout | output | 1 | Sticky IORDY timeout flag |
| cs0_n | output | 1 | Chip select 0, active low |
| cs1_n | output | 1 | Chip select 1, active low |
| da | output | 3 | Device address |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| dd_oe | output | 1 | Data bus output enable |
| dd_out | output | DW | Data bus output value |

## Verification
The bench builds the block with CNT_W=6, IORDY_MIN=3 and ACT_MAX=12. With these values the full IORDY window, the point where sampling first becomes allowed, and a transfer that hits the timeout all fit in a few dozen clocks. The bench can then place the IORDY release before, inside and beyond that window. The timing sets are programmed so that each of the three tail terms wins in at least one transfer: cycle minus active, minimum recovery, and the floor of one. The write hold is set to be cut short by a one-clock tail in one transfer and to fit entirely in another.

// File: rtl/ata_pio_pkg.sv
`timescale 1ns/1ps
package ata_pio_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_TAIL   = 2'd3
  } pio_phase_e;

  // A programmed count of zero still costs one clock.
  function automatic int unsigned at_least_one(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  // Clocks of write-data hold after the write strobe rises.
  function automatic logic [1:0] wr_hold_clocks(input logic [2:0] mode);
    if (mode == 3'd0)      return 2'd3;
    else if (mode <= 3'd2) return 2'd2;
    else                   return 2'd1;
  endfunction

  // Tail after the strobe: larger of the unused cycle time and the
  // minimum recovery, never below one clock.
  function automatic int unsigned tail_clocks(input int unsigned cyc,
                                              input int unsigned act_tot,
                                              input int unsigned rec);
    int unsigned rest;
    rest = (cyc > act_tot) ? (cyc - act_tot) : 0;
    if (rec > rest) rest = rec;
    return at_least_one(rest);
  endfunction

endpackage

// File: rtl/pio_iordy_sync.sv
`timescale 1ns/1ps
module pio_iordy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  pipe_q[i] <= 1'b0;
        else if (i == 0) pipe_q[i] <= d;
        else         pipe_q[i] <= pipe_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/pio_phase_ctl.sv
`timescale 1ns/1ps
module pio_phase_ctl
  import ata_pio_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int CW        = 9,
  parameter int IORDY_MIN = 5,
  parameter int ACT_MAX   = 160
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] setup_in,
  input  logic [CNT_W-1:0] act_in,
  input  logic [CNT_W-1:0] rec_in,
  input  logic [CNT_W-1:0] cyc_in,
  input  logic             iordy_use,
  input  logic             iordy_ok,
  output pio_phase_e       phase,
  output logic [CW-1:0]    cnt,
  output logic             act_exit,
  output logic             tail_end,
  output logic             iordy_expired
);
  localparam logic [CW-1:0] IMIN_C = CW'(IORDY_MIN);
  localparam logic [CW-1:0] AMAX_C = CW'(ACT_MAX);
  localparam logic [CW-1:0] ONE_C  = CW'(1);

  pio_phase_e phase_q;
  logic [CW-1:0] cnt_q, cnt_nx, tail_q;
  logic [CW-1:0] setup_q, act_q, rec_q, cyc_q;

  assign cnt_nx = cnt_q + ONE_C;

  // Events brought out as named wires.
  logic base_met, sample_ok, at_cap, setup_end;
  assign base_met  = (cnt_nx >= act_q);
  assign sample_ok = (cnt_q >= IMIN_C);
  assign at_cap    = (cnt_nx >= AMAX_C);
  assign setup_end = (phase_q == PH_SETUP) && (cnt_nx >= setup_q);
  assign act_exit  = (phase_q == PH_ACTIVE) && base_met &&
                     (!iordy_use || (sample_ok && (iordy_ok || at_cap)));
  assign iordy_expired = act_exit && iordy_use && !iordy_ok;
  assign tail_end  = (phase_q == PH_TAIL) && (cnt_nx >= tail_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      tail_q  <= '0;
      setup_q <= '0;
      act_q   <= '0;
      rec_q   <= '0;
      cyc_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start) begin
          setup_q <= CW'(at_least_one(32'(setup_in)));
          act_q   <= CW'(at_least_one(32'(act_in)));
          rec_q   <= CW'(rec_in);
          cyc_q   <= CW'(cyc_in);
          cnt_q   <= '0;
          phase_q <= PH_SETUP;
        end
        PH_SETUP: if (setup_end) begin
          cnt_q   <= '0;
          phase_q <= PH_ACTIVE;
        end else cnt_q <= cnt_nx;
        PH_ACTIVE: if (act_exit) begin
          tail_q  <= CW'(tail_clocks(32'(cyc_q), 32'(cnt_nx), 32'(rec_q)));
          cnt_q   <= '0;
          phase_q <= PH_TAIL;
        end else cnt_q <= cnt_nx;
        PH_TAIL: if (tail_end) begin
          cnt_q   <= '0;
          phase_q <= PH_IDLE;
        end else cnt_q <= cnt_nx;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase = phase_q;
  assign cnt   = cnt_q;

  AST_ACTIVE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ACTIVE) |-> ((cnt_q < act_q) || (cnt_q < AMAX_C) || (cnt_q <= IMIN_C))); // R9
  AST_TAIL_COVERS_RECOV: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_TAIL) |-> ((tail_q >= rec_q) && (tail_q != '0))); // R10
  AST_ACTIVE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ACTIVE && cnt_q == '0) |-> ($past(phase_q) == PH_SETUP)); // R3
endmodule

// File: rtl/pio_bus_drive.sv
`timescale 1ns/1ps
module pio_bus_drive
  import ata_pio_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 9
) (
  input  pio_phase_e    phase,
  input  logic [CW-1:0] cnt,
  input  logic [4:0]    sel,
  input  logic          write,
  input  logic [DW-1:0] wdata,
  input  logic [1:0]    hold,
  output logic          cs0_n,
  output logic          cs1_n,
  output logic [2:0]    da,
  output logic          rd_n,
  output logic          wr_n,
  output logic          dd_oe,
  output logic [DW-1:0] dd_out
);
  logic engaged, strobing, in_hold;

  assign engaged  = (phase != PH_IDLE);
  assign strobing = (phase == PH_ACTIVE);
  assign in_hold  = (phase == PH_TAIL) && (cnt < CW'(hold));

  assign cs0_n  = engaged ? sel[0] : 1'b1;
  assign cs1_n  = engaged ? sel[1] : 1'b1;
  assign da     = engaged ? sel[4:2] : 3'd0;
  assign rd_n   = !(strobing && !write);
  assign wr_n   = !(strobing && write);
  assign dd_oe  = write && (strobing || in_hold);
  assign dd_out = dd_oe ? wdata : '0;
endmodule

// File: rtl/ata_pio_seq.sv
`timescale 1ns/1ps
module ata_pio_seq
  import ata_pio_pkg::*;
#(
  parameter int DW        = 16,
  parameter int CNT_W     = 8,
  parameter int IORDY_MIN = 5,
  parameter int ACT_MAX   = 160
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [4:0]       req_sel,
  input  logic             req_wide,
  input  logic [DW-1:0]    req_wdata,
  input  logic [2:0]       pio_mode,
  input  logic             iordy_en,
  input  logic [CNT_W-1:0] reg_setup,
  input  logic [CNT_W-1:0] reg_active,
  input  logic [CNT_W-1:0] reg_recov,
  input  logic [CNT_W-1:0] reg_cycle,
  input  logic [CNT_W-1:0] dat_setup,
  input  logic [CNT_W-1:0] dat_active,
  input  logic [CNT_W-1:0] dat_recov,
  input  logic [CNT_W-1:0] dat_cycle,
  input  logic             iordy_in,
  input  logic [DW-1:0]    dd_in,
  output logic             busy,
  output logic             done,
  output logic [DW-1:0]    rdata,
  output logic             iordy_timeout,
  output logic             cs0_n,
  output logic             cs1_n,
  output logic [2:0]       da,
  output logic             rd_n,
  output logic             wr_n,
  output logic             dd_oe,
  output logic [DW-1:0]    dd_out
);
  localparam int LIM_W = $clog2(ACT_MAX + IORDY_MIN + 2);
  localparam int CW    = ((CNT_W > LIM_W) ? CNT_W : LIM_W) + 1;

  pio_phase_e    phase;
  logic [CW-1:0] cnt;
  logic          start, act_exit, tail_end, iordy_expired, iordy_sync;

  logic [4:0]    sel_q;
  logic          write_q, iordy_use_q;
  logic [DW-1:0] wdata_q;
  logic [1:0]    hold_q;

  assign start = req_valid && (phase == PH_IDLE);
  assign busy  = (phase != PH_IDLE);

  pio_iordy_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(iordy_in), .q(iordy_sync)
  );

  pio_phase_ctl #(
    .CNT_W(CNT_W), .CW(CW), .IORDY_MIN(IORDY_MIN), .ACT_MAX(ACT_MAX)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .setup_in(req_wide ? dat_setup  : reg_setup),
    .act_in  (req_wide ? dat_active : reg_active),
    .rec_in  (req_wide ? dat_recov  : reg_recov),
    .cyc_in  (req_wide ? dat_cycle  : reg_cycle),
    .iordy_use(iordy_use_q), .iordy_ok(iordy_sync),
    .phase(phase), .cnt(cnt), .act_exit(act_exit),
    .tail_end(tail_end), .iordy_expired(iordy_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q         <= 5'b00011;
      write_q       <= 1'b0;
      iordy_use_q   <= 1'b0;
      wdata_q       <= '0;
      hold_q        <= 2'd1;
      rdata         <= '0;
      done          <= 1'b0;
      iordy_timeout <= 1'b0;
    end else begin
      if (start) begin
        sel_q       <= req_sel;
        write_q     <= req_write;
        iordy_use_q <= iordy_en;
        wdata_q     <= req_wdata;
        hold_q      <= wr_hold_clocks(pio_mode);
      end
      if (act_exit && !write_q) rdata <= dd_in;
      done <= tail_end;
      if (iordy_expired) iordy_timeout <= 1'b1;
    end
  end

  pio_bus_drive #(.DW(DW), .CW(CW)) u_drive (
    .phase(phase), .cnt(cnt), .sel(sel_q), .write(write_q),
    .wdata(wdata_q), .hold(hold_q),
    .cs0_n(cs0_n), .cs1_n(cs1_n), .da(da), .rd_n(rd_n), .wr_n(wr_n),
    .dd_oe(dd_oe), .dd_out(dd_out)
  );

  AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs0_n && cs1_n && rd_n && wr_n && !dd_oe)); // R1
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!rd_n, !wr_n}) <= 1); // R4
  AST_STROBE_AFTER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_n) || $fell(wr_n)) |-> $past(busy)); // R3
  AST_OE_NOT_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    dd_oe |-> rd_n); // R6
  AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
  AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    iordy_timeout |=> iordy_timeout); // R9
endmodule

// File: tb/ata_pio_seq_test.sv
`timescale 1ns/1ps
module ata_pio_seq_test;
  localparam int DW = 16, CNT_W = 6, IMIN = 3, AMAX = 12;
  localparam logic [15:0] RD_BASE = 16'hA500;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_wide = 0, iordy_en = 0, iordy_in = 0;
  logic [4:0] req_sel = 0;
  logic [15:0] req_wdata = 0, dd_in = 16'hFFFF;
  logic [2:0] pio_mode = 0;
  logic [CNT_W-1:0] reg_setup = 2, reg_active = 4, reg_recov = 2, reg_cycle = 9;
  logic [CNT_W-1:0] dat_setup = 1, dat_active = 3, dat_recov = 1, dat_cycle = 5;
  logic busy, done, iordy_timeout, cs0_n, cs1_n, rd_n, wr_n, dd_oe;
  logic [2:0] da;
  logic [15:0] rdata, dd_out;

  always #4 clk = ~clk;

  ata_pio_seq #(.DW(DW), .CNT_W(CNT_W), .IORDY_MIN(IMIN), .ACT_MAX(AMAX)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_sel(req_sel), .req_wide(req_wide), .req_wdata(req_wdata),
    .pio_mode(pio_mode), .iordy_en(iordy_en),
    .reg_setup(reg_setup), .reg_active(reg_active), .reg_recov(reg_recov),
    .reg_cycle(reg_cycle), .dat_setup(dat_setup), .dat_active(dat_active),
    .dat_recov(dat_recov), .dat_cycle(dat_cycle), .iordy_in(iordy_in),
    .dd_in(dd_in), .busy(busy), .done(done), .rdata(rdata),
    .iordy_timeout(iordy_timeout), .cs0_n(cs0_n), .cs1_n(cs1_n), .da(da),
    .rd_n(rd_n), .wr_n(wr_n), .dd_oe(dd_oe), .dd_out(dd_out)
  );

  typedef struct {
    bit wr; logic [4:0] sel; logic [15:0] wd;
    int s; int a; int t; int o; string tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0;
  int m_s = 0, m_a = 0, m_t = 0, m_o = 0, cur_rel = 1;
  bit m_str = 0, exp_to = 0, finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic int imax(input int a, input int b); return (a > b) ? a : b; endfunction
  function automatic int imin(input int a, input int b); return (a < b) ? a : b; endfunction

  // Monitor: measures every transfer and compares at done.
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) begin
        if (q.size() == 0) chk(0, "R2 busy with no request queued", 1, 0);
        else begin
          chk({da, cs1_n, cs0_n} == q[0].sel, "R3 select held",
              int'({da, cs1_n, cs0_n}), int'(q[0].sel));
          if (!m_str && rd_n && wr_n) begin
            m_s++;
            chk(!dd_oe, "R6 no drive in setup", int'(dd_oe), 0);
          end else if (!rd_n || !wr_n) begin
            m_str = 1; m_a++;
            chk(q[0].wr ? (!wr_n && rd_n) : (!rd_n && wr_n), "R4 strobe choice",
                int'({rd_n, wr_n}), q[0].wr ? 2 : 1);
            if (q[0].wr)
              chk(dd_oe && dd_out == q[0].wd, "R6 data driven while wr_n low",
                  int'(dd_out), int'(q[0].wd));
          end else begin
            m_t++;
            if (dd_oe) m_o++;
          end
        end
      end
      dd_in    = (!rd_n) ? RD_BASE + 16'(m_a) : 16'hFFFF;
      iordy_in = (!rd_n || !wr_n) && (m_a >= cur_rel);
      if (done) begin
        if (q.size() == 0) chk(0, "R2 done with no request", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(m_s == e.s, {e.tag, " R3 setup clocks"}, m_s, e.s);
          chk(m_a == e.a, {e.tag, " R4 active clocks"}, m_a, e.a);
          chk(m_t == e.t, {e.tag, " R10 tail clocks"}, m_t, e.t);
          chk(m_o == e.o, {e.tag, " R6 hold clocks"}, m_o, e.o);
          if (!e.wr)
            chk(rdata == RD_BASE + 16'(e.a), {e.tag, " R5 read data"},
                int'(rdata), int'(RD_BASE + 16'(e.a)));
        end
        m_s = 0; m_a = 0; m_t = 0; m_o = 0; m_str = 0;
      end
    end
  end

  // Driver: computes the expected transfer and pushes it to the scoreboard.
  task automatic run(input bit wr, input logic [4:0] sel, input bit wide,
                     input logic [15:0] wd, input logic [2:0] mode,
                     input bit ien, input int rel, input bit intrude,
                     input string tag);
    exp_t e;
    int s, a, c, r, hold;
    s = imax(wide ? int'(dat_setup) : int'(reg_setup), 1);
    a = imax(wide ? int'(dat_active) : int'(reg_active), 1);
    c = wide ? int'(dat_cycle) : int'(reg_cycle);
    r = wide ? int'(dat_recov) : int'(reg_recov);
    if (ien) a = imax(imax(a, IMIN + 1), imin(rel + 2, AMAX));
    if (ien && a < rel + 2) exp_to = 1;
    hold = (mode == 0) ? 3 : ((mode <= 2) ? 2 : 1);
    e.wr = wr; e.sel = sel; e.wd = wd; e.s = s; e.a = a;
    e.t = imax(imax(c - a, r), 1);
    e.o = wr ? imin(hold, e.t) : 0;
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_sel = sel; req_wide = wide;
    req_wdata = wd; pio_mode = mode; iordy_en = ien; cur_rel = rel;
    @(negedge clk);
    if (intrude) begin
      req_sel = ~sel; req_write = !wr; req_wide = !wide; req_wdata = ~wd;
    end else req_valid = 0;
    while (!done) @(negedge clk);
    req_valid = 0;
    chk(iordy_timeout == exp_to, {tag, " R9 timeout flag"}, int'(iordy_timeout), int'(exp_to));
    @(negedge clk);
    @(negedge clk);
    chk(!busy && cs0_n && cs1_n && rd_n && wr_n && !dd_oe, {tag, " R1 idle after transfer"},
        int'({busy, cs0_n, cs1_n, rd_n, wr_n, dd_oe}), 8'b011110);
    if (intrude) chk(!busy, {tag, " R2 no second transfer"}, int'(busy), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs0_n && cs1_n && rd_n && wr_n && !dd_oe && !busy && !done, "R1 in reset",
        int'({cs0_n, cs1_n, rd_n, wr_n, dd_oe, busy, done}), 7'b1111000);
    rst_n = 1;
    @(negedge clk);
    chk(cs0_n && cs1_n && rd_n && wr_n && !busy && !iordy_timeout, "R1 after reset",
        int'({cs0_n, cs1_n, rd_n, wr_n, busy, iordy_timeout}), 6'b111100);

    run(0, 5'h0E, 0, 16'h0000, 3'd0, 0, 1, 0, "reg read R7");
    run(1, 5'h19, 0, 16'h00C3, 3'd0, 0, 1, 0, "reg write mode0");
    run(1, 5'h02, 1, 16'h1234, 3'd1, 0, 1, 0, "data write mode1 R7");
    run(0, 5'h02, 1, 16'h0000, 3'd2, 0, 1, 0, "data read R7");
    run(1, 5'h02, 1, 16'hBEEF, 3'd4, 0, 1, 0, "data write mode4");
    dat_setup = 0; dat_active = 0; dat_recov = 0; dat_cycle = 0;
    run(1, 5'h02, 1, 16'h5A5A, 3'd0, 0, 1, 0, "zero counts write R11");
    run(0, 5'h02, 1, 16'h0000, 3'd0, 0, 1, 0, "zero counts read R11");
    reg_recov = 7;
    run(0, 5'h1E, 0, 16'h0000, 3'd0, 0, 1, 0, "recovery wins R10");
    reg_recov = 2;
    run(0, 5'h1E, 0, 16'h0000, 3'd0, 1, 6, 0, "iordy stretch R8");
    run(1, 5'h0A, 0, 16'h0077, 3'd3, 1, 1, 0, "iordy early ready R8");
    run(0, 5'h12, 0, 16'h0000, 3'd0, 1, 50, 0, "iordy timeout R9");
    run(0, 5'h0E, 0, 16'h0000, 3'd0, 0, 1, 0, "timeout stays R9");
    run(1, 5'h16, 0, 16'h4321, 3'd2, 0, 1, 1, "request while busy R2");
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R2 scoreboard drained", q.size(), 0);
    summary();
  end
endmodule